// File: doc/BRIEF.md
# Serial ADC Capture Controller

This block is the host-side master for a 12-bit successive-approximation converter that is read over a three-wire serial link: an active-low chip select, a shift clock and a serial data line. It runs on a fast system clock and derives the shift clock from it with a fixed divider. Each frame begins when chip select falls while the shift clock is low. The converter then presents two zero bits, twelve data bits with the most significant bit first, and two trailing zeros. It changes the data line on shift-clock falling edges. The controller samples every bit on the rising edges.

A conversion request runs either a 14-clock or a 16-clock frame, chosen by a mode input. The controller checks the two leading zeros. It then publishes the 12-bit result with a one-cycle strobe, or raises a framing error instead. A sleep request cuts a frame short after a set number of falling edges, which puts the converter into its low-power state. A wake request runs a full 16-clock dummy frame and discards its data. The converter is ready only once that frame ends. Between frames, chip select stays high for a programmable number of system clocks so that the converter has time to acquire the next sample.

Top module: `adc_serial_ctrl`

## Requirements
- R1: After reset, cs_n_o is 1, sck_o is 0, result_valid_o and frame_err_o are 0, busy_o is 0 and powered_o is 0 (the converter is taken to be asleep).
- R2: sck_o is 0 whenever cs_n_o is 1. While a frame runs, each shift-clock half period lasts DIV_HALF system clocks, and the first rising edge comes DIV_HALF clocks after cs_n_o falls. cs_n_o changes only while sck_o is 0.
- R3: A conversion frame ends, with cs_n_o rising, on the 14th shift-clock falling edge when long_frame_i was 0 at the request, and on the 16th falling edge when it was 1.
- R4: Bits are sampled on shift-clock rising edges. Stream bit k (k = 1..16) is taken on rising edge k. Bits 3 to 14 form result_o, with bit 3 as result_o[11]. One clock after the 14th rising edge, result_valid_o pulses for exactly one cycle if bits 1 and 2 were both 0.
- R5: If either leading bit of a conversion frame reads 1, frame_err_o pulses for one cycle in place of result_valid_o, and result_o keeps its previous value.
- R6: A sleep frame ends, with cs_n_o rising, on falling edge number SLEEP_FALLS (default 4, allowed 3 to 9). It clears powered_o on that same edge and produces neither strobe.
- R7: A wake frame always runs 16 falling edges. It produces neither strobe, leaves result_o unchanged, and sets powered_o on the edge where cs_n_o rises.
- R8: Between the end of one frame and the start of the next, cs_n_o stays 1 for at least GAP_CLKS system clocks.
- R9: Requests are single-cycle inputs and are acted on only while busy_o is 0. A conversion or sleep request is acted on only when powered_o is 1. A wake request is acted on only when powered_o is 0. Any request that does not qualify is dropped and starts no frame.
- R10: When several qualifying requests arrive in the same idle cycle, a conversion takes precedence over a sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_req_i | input | 1 | Request one conversion frame |
| sleep_req_i | input | 1 | Request a shortened frame that puts the converter to sleep |
| wake_req_i | input | 1 | Request a dummy frame that powers the converter up |
| long_frame_i | input | 1 | 1 selects a 16-clock conversion frame, 0 a 14-clock frame |
| sdo_i | input | 1 | Serial data from the converter |
| sck_o | output | 1 | Shift clock to the converter, low when idle |
| cs_n_o | output | 1 | Active-low chip select |
| result_o | output | DATA_W | Last valid conversion result |
| result_valid_o | output | 1 | One-cycle strobe for a new result |
| frame_err_o | output | 1 | One-cycle strobe when a leading zero was not seen |
| busy_o | output | 1 | A frame or the inter-frame gap is in progress |
| powered_o | output | 1 | The converter is awake and can convert |

## Verification
On every cycle the assertions check that the shift clock is low whenever chip select is high, and that chip select changes only with the clock low. They also check that the two strobes are single-cycle and never both high, that the power flag changes only on a frame's final edge, and that the high time between frames meets the gap. The bench scenarios cover the rest: the number of falling edges for each frame type, the bit order of the assembled result, discarding of the wake frame, suppression of the result on a bad leading zero, and the rules that drop requests.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_GAP   = 2'd2
   } ctrl_state_t;

   typedef enum logic [1:0] {
      FR_CONV  = 2'd0,
      FR_SLEEP = 2'd1,
      FR_WAKE  = 2'd2
   } frame_kind_t;
endpackage

// File: rtl/adc_sck_gen.sv
module adc_sck_gen #(
   parameter int DIV_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sck,
   output logic rise_p,
   output logic fall_p
);
   localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

   logic sck_q;
   logic tick;

   generate
      if (DIV_HALF < 1) begin : g_bad_div
         $error("adc_sck_gen: DIV_HALF must be at least 1");
      end

      if (DIV_HALF == 1) begin : g_direct
         assign tick = run;
      end else begin : g_divided
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (!run || div_q == DIV_W'(DIV_HALF - 1)) begin
               div_q <= '0;
            end else begin
               div_q <= div_q + DIV_W'(1);
            end
         end
         assign tick = run && (div_q == DIV_W'(DIV_HALF - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
      end else if (!run) begin
         sck_q <= 1'b0;
      end else if (tick) begin
         sck_q <= ~sck_q;
      end
   end

   assign sck    = sck_q;
   assign rise_p = tick && !sck_q;
   assign fall_p = tick && sck_q;
endmodule

// File: rtl/adc_shift_capture.sv
module adc_shift_capture #(
   parameter int DATA_W = 12,
   parameter int LEAD_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              cap,
   input  logic              sdo,
   input  logic              publish,
   output logic [DATA_W-1:0] data,
   output logic              valid,
   output logic              err
);
   localparam int WORD_W = LEAD_W + DATA_W;
   localparam int CNT_W  = $clog2(WORD_W + 1);

   logic [WORD_W-2:0] shreg_q;
   logic [CNT_W-1:0]  rise_q;
   logic [WORD_W-1:0] word_now;
   logic              last_bit;
   logic              lead_ok;

   assign word_now = {shreg_q, sdo};
   assign last_bit = cap && (rise_q == CNT_W'(WORD_W - 1));
   assign lead_ok  = (word_now[WORD_W-1 -: LEAD_W] == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         rise_q  <= '0;
      end else if (clear) begin
         rise_q  <= '0;
      end else if (cap) begin
         shreg_q <= word_now[WORD_W-2:0];
         if (rise_q != CNT_W'(WORD_W)) begin
            rise_q <= rise_q + CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data  <= '0;
         valid <= 1'b0;
         err   <= 1'b0;
      end else begin
         valid <= last_bit && publish && lead_ok;
         err   <= last_bit && publish && !lead_ok;
         if (last_bit && publish && lead_ok) begin
            data <= word_now[DATA_W-1:0];
         end
      end
   end
endmodule

// File: rtl/adc_frame_fsm.sv
module adc_frame_fsm
   import adc_ctrl_pkg::*;
#(
   parameter int FRAME_SHORT = 14,
   parameter int FRAME_LONG  = 16,
   parameter int SLEEP_FALLS = 4,
   parameter int GAP_CLKS    = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        conv_req,
   input  logic        sleep_req,
   input  logic        wake_req,
   input  logic        long_frame,
   input  logic        fall_p,
   output logic        cs_n,
   output logic        run,
   output logic        start_p,
   output frame_kind_t kind,
   output logic        busy,
   output logic        powered
);
   localparam int CNT_W = $clog2(FRAME_LONG + 1);
   localparam int GAP_W = $clog2(GAP_CLKS + 1);

   ctrl_state_t      state_q;
   frame_kind_t      kind_q, go_kind;
   logic [CNT_W-1:0] lim_q, go_lim, fall_q;
   logic [GAP_W-1:0] gap_q;
   logic             cs_n_q, powered_q, go;

   always_comb begin
      go      = 1'b0;
      go_kind = FR_CONV;
      go_lim  = CNT_W'(FRAME_SHORT);
      if (state_q == ST_IDLE) begin
         if (conv_req && powered_q) begin
            go     = 1'b1;
            go_lim = long_frame ? CNT_W'(FRAME_LONG) : CNT_W'(FRAME_SHORT);
         end else if (sleep_req && powered_q) begin
            go      = 1'b1;
            go_kind = FR_SLEEP;
            go_lim  = CNT_W'(SLEEP_FALLS);
         end else if (wake_req && !powered_q) begin
            go      = 1'b1;
            go_kind = FR_WAKE;
            go_lim  = CNT_W'(FRAME_LONG);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         kind_q    <= FR_CONV;
         lim_q     <= '0;
         fall_q    <= '0;
         gap_q     <= '0;
         cs_n_q    <= 1'b1;
         powered_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (go) begin
                  state_q <= ST_SHIFT;
                  cs_n_q  <= 1'b0;
                  fall_q  <= '0;
                  kind_q  <= go_kind;
                  lim_q   <= go_lim;
               end
            end
            ST_SHIFT: begin
               if (fall_p) begin
                  fall_q <= fall_q + CNT_W'(1);
                  if (fall_q == lim_q - CNT_W'(1)) begin
                     state_q <= ST_GAP;
                     cs_n_q  <= 1'b1;
                     gap_q   <= '0;
                     if (kind_q == FR_SLEEP) powered_q <= 1'b0;
                     if (kind_q == FR_WAKE)  powered_q <= 1'b1;
                  end
               end
            end
            ST_GAP: begin
               gap_q <= gap_q + GAP_W'(1);
               if (gap_q == GAP_W'(GAP_CLKS - 1)) begin
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cs_n    = cs_n_q;
   assign run     = (state_q == ST_SHIFT);
   assign start_p = go;
   assign kind    = kind_q;
   assign busy    = (state_q != ST_IDLE);
   assign powered = powered_q;
endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl
   import adc_ctrl_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int LEAD_W      = 2,
   parameter int TRAIL_W     = 2,
   parameter int DIV_HALF    = 2,
   parameter int GAP_CLKS    = 6,
   parameter int SLEEP_FALLS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_req_i,
   input  logic              sleep_req_i,
   input  logic              wake_req_i,
   input  logic              long_frame_i,
   input  logic              sdo_i,
   output logic              sck_o,
   output logic              cs_n_o,
   output logic [DATA_W-1:0] result_o,
   output logic              result_valid_o,
   output logic              frame_err_o,
   output logic              busy_o,
   output logic              powered_o
);
   localparam int FRAME_SHORT = LEAD_W + DATA_W;
   localparam int FRAME_LONG  = FRAME_SHORT + TRAIL_W;
   localparam int SLEEP_MIN   = 3;
   localparam int SLEEP_MAX   = 9;

   generate
      if (SLEEP_FALLS < SLEEP_MIN || SLEEP_FALLS > SLEEP_MAX) begin : g_bad_sleep
         $error("adc_serial_ctrl: SLEEP_FALLS out of range");
      end
      if (GAP_CLKS < 2 * DIV_HALF) begin : g_bad_gap
         $error("adc_serial_ctrl: GAP_CLKS shorter than one shift-clock period");
      end
      if (LEAD_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("adc_serial_ctrl: widths must be positive");
      end
   endgenerate

   logic        run, rise_p, fall_p, start_p;
   frame_kind_t kind;

   adc_sck_gen #(.DIV_HALF(DIV_HALF)) u_sck (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .sck    (sck_o),
      .rise_p (rise_p),
      .fall_p (fall_p)
   );

   adc_frame_fsm #(
      .FRAME_SHORT (FRAME_SHORT),
      .FRAME_LONG  (FRAME_LONG),
      .SLEEP_FALLS (SLEEP_FALLS),
      .GAP_CLKS    (GAP_CLKS)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .conv_req   (conv_req_i),
      .sleep_req  (sleep_req_i),
      .wake_req   (wake_req_i),
      .long_frame (long_frame_i),
      .fall_p     (fall_p),
      .cs_n       (cs_n_o),
      .run        (run),
      .start_p    (start_p),
      .kind       (kind),
      .busy       (busy_o),
      .powered    (powered_o)
   );

   adc_shift_capture #(.DATA_W(DATA_W), .LEAD_W(LEAD_W)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (start_p),
      .cap     (rise_p),
      .sdo     (sdo_i),
      .publish (kind == FR_CONV),
      .data    (result_o),
      .valid   (result_valid_o),
      .err     (frame_err_o)
   );
endmodule

// File: rtl/adc_serial_ctrl_chk.sv
module adc_serial_ctrl_chk #(
   parameter int GAP_CLKS = 6
) (
   input logic clk,
   input logic rst_n,
   input logic cs_n_o,
   input logic sck_o,
   input logic result_valid_o,
   input logic frame_err_o,
   input logic powered_o
);
   localparam int HI_W = $clog2(GAP_CLKS + 1) + 1;

   logic [HI_W-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= HI_W'(GAP_CLKS);
      end else if (!cs_n_o) begin
         hi_cnt <= '0;
      end else if (hi_cnt < HI_W'(GAP_CLKS)) begin
         hi_cnt <= hi_cnt + HI_W'(1);
      end
   end

   a_r2_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> !sck_o);

   a_r2_cs_moves_with_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cs_n_o) |-> !sck_o);

   a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid_o |=> !result_valid_o);

   a_r5_err_excludes_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !(result_valid_o && frame_err_o));

   a_r5_err_single: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_o |=> !frame_err_o);

   a_r7_power_on_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(powered_o) |-> $rose(cs_n_o));

   a_r8_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_o) |-> (hi_cnt >= HI_W'(GAP_CLKS)));
endmodule

bind adc_serial_ctrl adc_serial_ctrl_chk #(.GAP_CLKS(GAP_CLKS)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cs_n_o         (cs_n_o),
   .sck_o          (sck_o),
   .result_valid_o (result_valid_o),
   .frame_err_o    (frame_err_o),
   .powered_o      (powered_o)
);

// File: tb/adc_serial_ctrl_tb.sv
module adc_serial_ctrl_tb;
   localparam int CLK_PERIOD  = 10;
   localparam int DIV_HALF    = 2;
   localparam int GAP_CLKS    = 6;
   localparam int SLEEP_FALLS = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv_req = 1'b0, sleep_req = 1'b0, wake_req = 1'b0, long_frame = 1'b0;
   logic        sdo = 1'b1;
   logic        sck, cs_n, valid, ferr, busy, powered;
   logic [11:0] result;

   int checks = 0, errors = 0;
   bit finished = 1'b0;

   // converter model
   logic [1:0]  lead_bits = 2'b00;
   logic [11:0] adc_data = '0;
   logic [15:0] stream;
   int          idx = 0;

   // monitor state
   int  falls = 0, last_falls = -1, frames = 0, high_cnt = 1000;
   int  valid_cnt = 0, err_cnt = 0, rise_first = -1, cyc_since_fall = 0;
   logic prev_cs = 1'b1, prev_sck = 1'b0, prev_valid = 1'b0;
   logic [11:0] last_result = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_serial_ctrl #(
      .DIV_HALF(DIV_HALF), .GAP_CLKS(GAP_CLKS), .SLEEP_FALLS(SLEEP_FALLS)
   ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .conv_req_i(conv_req), .sleep_req_i(sleep_req), .wake_req_i(wake_req),
      .long_frame_i(long_frame), .sdo_i(sdo),
      .sck_o(sck), .cs_n_o(cs_n), .result_o(result),
      .result_valid_o(valid), .frame_err_o(ferr),
      .busy_o(busy), .powered_o(powered)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   always @(negedge cs_n) begin
      stream = {lead_bits, adc_data, 2'b00};
      idx = 0;
      sdo = stream[15];
   end
   always @(negedge sck) begin
      if (!cs_n) begin
         idx++;
         if (idx < 16) sdo = stream[15-idx];
      end
   end
   always @(posedge cs_n) sdo = 1'b1;

   // per-clock reference checks
   always @(negedge clk) begin
      if (rst_n) begin
         if (cs_n && sck) chk(1'b0, "R2 sck high while cs_n high", 1, 0);
         if (!prev_cs && prev_sck && !sck) falls++;
         if (!cs_n) begin
            cyc_since_fall++;
            if (!prev_sck && sck && rise_first < 0) rise_first = cyc_since_fall;
         end
         if (prev_cs && !cs_n) begin
            chk(high_cnt >= GAP_CLKS, "R8 gap before frame", high_cnt, GAP_CLKS);
            falls = 0; frames++; cyc_since_fall = 0; rise_first = -1;
         end
         if (!prev_cs && cs_n) begin
            last_falls = falls;
            high_cnt = 0;
         end
         if (cs_n) high_cnt++;
         if (valid) begin valid_cnt++; last_result = result; end
         if (ferr) err_cnt++;
         if (valid && prev_valid) chk(1'b0, "R4 valid longer than one cycle", 2, 1);
      end
      prev_cs = cs_n; prev_sck = sck; prev_valid = valid;
   end

   task automatic pulse(input bit c, input bit s, input bit w);
      @(negedge clk);
      conv_req = c; sleep_req = s; wake_req = w;
      @(negedge clk);
      conv_req = 1'b0; sleep_req = 1'b0; wake_req = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (!busy) break;
      end
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         chk(1'b0, "watchdog expired", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int f0, v0, e0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
      chk(sck == 1'b0, "R1 sck", sck, 0);
      chk(valid == 1'b0 && ferr == 1'b0, "R1 strobes", valid | ferr, 0);
      chk(busy == 1'b0, "R1 busy", busy, 0);
      chk(powered == 1'b0, "R1 powered", powered, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R9 conversion and sleep dropped while asleep
      f0 = frames;
      pulse(1, 0, 0); pulse(0, 1, 0);
      repeat (30) @(negedge clk);
      chk(frames == f0, "R9 request while asleep", frames, f0);

      // R7 wake dummy frame
      adc_data = 12'h5A5;
      pulse(0, 0, 1); wait_idle();
      chk(last_falls == 16, "R7 wake frame length", last_falls, 16);
      chk(valid_cnt == 0 && err_cnt == 0, "R7 wake strobes", valid_cnt + err_cnt, 0);
      chk(powered == 1'b1, "R7 powered after wake", powered, 1);
      chk(result == 12'h000, "R7 result untouched", result, 0);
      chk(rise_first == DIV_HALF, "R2 first rise delay", rise_first, DIV_HALF);

      // R9 wake dropped while powered
      f0 = frames;
      pulse(0, 0, 1); repeat (30) @(negedge clk);
      chk(frames == f0, "R9 wake while powered", frames, f0);

      // R3 R4 short frame
      adc_data = 12'hA5C; long_frame = 1'b0; v0 = valid_cnt;
      pulse(1, 0, 0); wait_idle();
      chk(last_falls == 14, "R3 short frame", last_falls, 14);
      chk(valid_cnt == v0 + 1, "R4 one strobe", valid_cnt, v0 + 1);
      chk(last_result == 12'hA5C, "R4 result short", last_result, 12'hA5C);

      // R3 R4 long frame
      adc_data = 12'h3F1; long_frame = 1'b1;
      pulse(1, 0, 0); wait_idle();
      chk(last_falls == 16, "R3 long frame", last_falls, 16);
      chk(result == 12'h3F1, "R4 result long", result, 12'h3F1);

      // R4 extreme codes
      adc_data = 12'hFFF; long_frame = 1'b0;
      pulse(1, 0, 0); wait_idle();
      chk(result == 12'hFFF, "R4 all ones", result, 12'hFFF);
      adc_data = 12'h000;
      pulse(1, 0, 0); wait_idle();
      chk(result == 12'h000, "R4 all zeros", result, 0);

      // R5 framing errors on either leading bit
      for (int k = 1; k <= 2; k++) begin
         lead_bits = 2'(k); adc_data = 12'h777; v0 = valid_cnt; e0 = err_cnt;
         pulse(1, 0, 0); wait_idle();
         chk(err_cnt == e0 + 1, "R5 error strobe", err_cnt, e0 + 1);
         chk(valid_cnt == v0, "R5 valid suppressed", valid_cnt, v0);
         chk(result == 12'h000, "R5 result held", result, 0);
      end
      lead_bits = 2'b00;

      // R9 request during busy frame dropped
      adc_data = 12'h0C3; f0 = frames;
      pulse(1, 0, 0); repeat (8) @(negedge clk);
      pulse(1, 0, 0); pulse(0, 1, 0);
      wait_idle(); repeat (20) @(negedge clk);
      chk(frames == f0 + 1, "R9 request while busy", frames, f0 + 1);
      chk(powered == 1'b1, "R9 sleep while busy dropped", powered, 1);

      // R10 conversion wins over sleep
      adc_data = 12'h456;
      pulse(1, 1, 0); wait_idle();
      chk(last_falls == 14, "R10 conversion chosen", last_falls, 14);
      chk(powered == 1'b1, "R10 still powered", powered, 1);
      chk(result == 12'h456, "R10 result", result, 12'h456);

      // R6 sleep frame
      v0 = valid_cnt; e0 = err_cnt;
      pulse(0, 1, 0); wait_idle();
      chk(last_falls == SLEEP_FALLS, "R6 sleep frame length", last_falls, SLEEP_FALLS);
      chk(powered == 1'b0, "R6 powered cleared", powered, 0);
      chk(valid_cnt == v0 && err_cnt == e0, "R6 no strobes", valid_cnt - v0 + err_cnt - e0, 0);

      // R9 sleep while asleep dropped
      f0 = frames;
      pulse(0, 1, 0); repeat (30) @(negedge clk);
      chk(frames == f0, "R9 sleep while asleep", frames, f0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule